// File: doc/BRIEF.md
# Pixel Clock Synthesizer Setting Search

This block turns a requested pixel period, given in picoseconds, into a three-field setting for a frequency synthesizer. The setting has a multiplier-side count `k`, a divider-side count `n` and a power-of-two post-scaler exponent `p`. The output period is roughly `256016 * k / n` picoseconds shifted right by `p`. A single start pulse launches the search. The block walks every legal `k` in turn. For each one it divides the scaled constant by the scaled request with a shared restoring divider, and it keeps the candidate whose remainder is smallest.

When the search is over, the same divider runs the reverse calculation on the winning setting and reports the period that setting really gives. The finished result comes with a one-cycle completion pulse. An error flag is raised when the request is too slow to encode, or when no candidate meets the bounds on `n`. Only the search is in scope. Sending the setting to the synthesizer and generating the clock are left to neighbouring logic.

Top module: `pxs_search_top`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `err_o` are low, and `k_o`, `n_o`, `p_o` and `period_out_o` are zero.
- R2: A start is taken only while the block is idle. A start that arrives while `busy_o` is high has no effect on the result of the search in progress. Outputs change only in the cycle where `done_o` is high.
- R3: A requested period below 5000 is handled exactly as a request of 5000.
- R4: A clamped period greater than 256016 shifted left by 3 (2048128) is rejected. `done_o` pulses in the cycle after the start with `err_o` = 1, and `k_o`, `n_o`, `p_o` and `period_out_o` are all zero.
- R5: The exponent `p_o` is 3 when the clamped period times 16 is less than 256016, and 2 otherwise. For example, 16000 gives 3 and 16001 gives 2.
- R6: With `l` = clamped period shifted left by `p`, every `k` from 1 to 31 is tried with `n` = (256016·k) / l and remainder (256016·k) mod l. A candidate is accepted when 1 ≤ `n` ≤ 127 and its remainder is strictly below the best so far. The best-so-far remainder starts at `l`. On a tie the smaller `k` is kept. The final best is reported on `k_o` and `n_o`.
- R7: If no candidate is accepted, the result is an error. `err_o` = 1 and all result fields are zero.
- R8: On success, `period_out_o` equals ((256016·k_o) / n_o) shifted right by `p_o`, using integer division.
- R9: `done_o` is a single-cycle pulse and is never high together with `busy_o`. `busy_o` rises only in the cycle after an accepted start and stays high until the cycle in which `done_o` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launches a search when idle |
| period_i | input | 24 | Requested pixel period in picoseconds |
| busy_o | output | 1 | Search or reverse calculation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request rejected or no valid setting found |
| k_o | output | 5 | Chosen numerator count |
| n_o | output | 7 | Chosen denominator count |
| p_o | output | 2 | Chosen post-scaler exponent |
| period_out_o | output | 24 | Period the chosen setting produces |

## Verification
Requests at 0 and 4999 are compared against 5000 to show that the floor is applied before any other step. The pair 16000/16001 separates the two exponent choices. The pair 2048128/2048129 separates the two error causes: 2048129 is rejected on entry, while 2048128 is accepted but leaves every quotient at zero. Neighbours such as 2000000 and 1900000 sit on either side of the point where a quotient of 1 first becomes reachable. A stride sweep across the whole legal range compares every field with an arithmetic model of the search, which catches errors in the remainder ordering, the tie rule and the `n` bound. A second start issued mid-search shows that the first request's answer survives.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_BACK,
        ST_BISSUE,
        ST_BWAIT
    } ctl_state_e;

    // Raise a period to the given floor.
    function automatic logic [31:0] clamp_floor(input logic [31:0] v,
                                                input logic [31:0] floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction

    // Post-scaler exponent: 3 for short periods, 2 otherwise.
    function automatic logic [1:0] pick_exp(input logic [31:0] per,
                                            input logic [31:0] base);
        logic [35:0] scaled;
        scaled = {per, 4'b0000};
        return (scaled < {4'b0000, base}) ? 2'd3 : 2'd2;
    endfunction

endpackage

// File: rtl/pxs_restoring_div.sv
module pxs_restoring_div #(
    parameter int unsigned DW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          valid,
    output logic [DW-1:0] quot,
    output logic [DW-1:0] rem
);
    localparam int unsigned CW = $clog2(DW + 1);

    logic [DW:0]   acc_q, acc_n, shifted;
    logic [DW-1:0] q_q, q_n;
    logic [CW-1:0] cnt_q;
    logic          active_q;

    always_comb begin
        shifted = {acc_q[DW-1:0], q_q[DW-1]};
        if (shifted >= {1'b0, divisor}) begin
            acc_n = shifted - {1'b0, divisor};
            q_n   = {q_q[DW-2:0], 1'b1};
        end else begin
            acc_n = shifted;
            q_n   = {q_q[DW-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            q_q      <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            valid    <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go) begin
                acc_q    <= '0;
                q_q      <= dividend;
                cnt_q    <= CW'(DW);
                active_q <= 1'b1;
            end else if (active_q) begin
                acc_q <= acc_n;
                q_q   <= q_n;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    active_q <= 1'b0;
                    valid    <= 1'b1;
                end
            end
        end
    end

    assign quot = q_q;
    assign rem  = acc_q[DW-1:0];
endmodule

// File: rtl/pxs_best_keeper.sv
module pxs_best_keeper #(
    parameter int unsigned DW = 24,
    parameter int unsigned KW = 5,
    parameter int unsigned NW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [DW-1:0] init_rem,
    input  logic          cand_v,
    input  logic [KW-1:0] cand_k,
    input  logic [DW-1:0] cand_q,
    input  logic [DW-1:0] cand_rem,
    output logic [KW-1:0] best_k,
    output logic [NW-1:0] best_n
);
    logic [DW-1:0] best_rem_q;
    logic          in_range, better, accept;

    // n must be nonzero and fit in NW bits; the strict compare keeps the earlier k on a tie
    assign in_range = (cand_q != '0) && (cand_q[DW-1:NW] == '0);
    assign better   = cand_rem < best_rem_q;
    assign accept   = cand_v && in_range && better;

    always_ff @(posedge clk) begin
        if (rst) begin
            best_rem_q <= '0;
            best_k     <= '0;
            best_n     <= '0;
        end else if (clr) begin
            best_rem_q <= init_rem;
            best_k     <= '0;
            best_n     <= '0;
        end else if (accept) begin
            best_rem_q <= cand_rem;
            best_k     <= cand_k;
            best_n     <= cand_q[NW-1:0];
        end
    end
endmodule

// File: rtl/pxs_search_top.sv
module pxs_search_top
    import pxs_pkg::*;
#(
    parameter int unsigned PW      = 24,
    parameter int unsigned KW      = 5,
    parameter int unsigned NW      = 7,
    parameter int unsigned XW      = 2,
    parameter int unsigned BASE    = 256016,
    parameter int unsigned MIN_PER = 5000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [PW-1:0] period_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic [KW-1:0] k_o,
    output logic [NW-1:0] n_o,
    output logic [XW-1:0] p_o,
    output logic [PW-1:0] period_out_o
);
    localparam int unsigned KMAX   = (1 << KW) - 1;
    localparam int unsigned MAXPER = BASE << 3;
    localparam int unsigned LW     = $clog2((BASE << 6) + 1);
    localparam int unsigned MW     = $clog2(BASE * KMAX + 1);
    localparam int unsigned DW     = (MW > LW) ? MW : LW;

    ctl_state_e    state_q;
    logic [DW-1:0] l_q, m_q;
    logic [XW-1:0] p_q;
    logic [KW-1:0] k_q;

    logic [31:0]   per_c;
    logic          reject_c;
    logic [1:0]    p_c;
    logic [DW-1:0] l_c;

    logic          dv_go, dv_valid;
    logic [DW-1:0] dv_num, dv_den, dv_quot, dv_rem;
    logic          search_phase;

    logic          keep_clr, cand_v;
    logic [KW-1:0] best_k;
    logic [NW-1:0] best_n;
    logic [DW-1:0] back_num;

    // Entry stage: floor, range check, exponent choice and scaled target
    assign per_c    = clamp_floor(32'(period_i), MIN_PER);
    assign reject_c = per_c > MAXPER;
    assign p_c      = pick_exp(per_c, BASE);
    assign l_c      = DW'(per_c) << p_c;

    assign search_phase = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
    assign back_num     = DW'(BASE) * DW'(best_k);
    assign dv_num       = search_phase ? m_q : back_num;
    assign dv_den       = search_phase ? l_q : DW'(best_n);
    assign dv_go        = (state_q == ST_ISSUE) || (state_q == ST_BISSUE);

    assign keep_clr = (state_q == ST_IDLE) && start_i && !reject_c;
    assign cand_v   = (state_q == ST_WAIT) && dv_valid;

    pxs_restoring_div #(.DW(DW)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (dv_go),
        .dividend (dv_num),
        .divisor  (dv_den),
        .valid    (dv_valid),
        .quot     (dv_quot),
        .rem      (dv_rem)
    );

    pxs_best_keeper #(.DW(DW), .KW(KW), .NW(NW)) u_keep (
        .clk      (clk),
        .rst      (rst),
        .clr      (keep_clr),
        .init_rem (l_c),
        .cand_v   (cand_v),
        .cand_k   (k_q),
        .cand_q   (dv_quot),
        .cand_rem (dv_rem),
        .best_k   (best_k),
        .best_n   (best_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            l_q          <= '0;
            m_q          <= '0;
            p_q          <= '0;
            k_q          <= '0;
            done_o       <= 1'b0;
            err_o        <= 1'b0;
            k_o          <= '0;
            n_o          <= '0;
            p_o          <= '0;
            period_out_o <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (reject_c) begin
                            done_o       <= 1'b1;
                            err_o        <= 1'b1;
                            k_o          <= '0;
                            n_o          <= '0;
                            p_o          <= '0;
                            period_out_o <= '0;
                        end else begin
                            l_q     <= l_c;
                            p_q     <= XW'(p_c);
                            k_q     <= KW'(1);
                            m_q     <= DW'(BASE);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (dv_valid) begin
                        if (k_q == KW'(KMAX)) begin
                            state_q <= ST_BACK;
                        end else begin
                            k_q     <= k_q + 1'b1;
                            m_q     <= m_q + DW'(BASE);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_BACK: begin
                    if (best_k == '0) begin
                        done_o       <= 1'b1;
                        err_o        <= 1'b1;
                        k_o          <= '0;
                        n_o          <= '0;
                        p_o          <= '0;
                        period_out_o <= '0;
                        state_q      <= ST_IDLE;
                    end else begin
                        state_q <= ST_BISSUE;
                    end
                end
                ST_BISSUE: state_q <= ST_BWAIT;
                ST_BWAIT: begin
                    if (dv_valid) begin
                        done_o       <= 1'b1;
                        err_o        <= 1'b0;
                        k_o          <= best_k;
                        n_o          <= best_n;
                        p_o          <= p_q;
                        period_out_o <= PW'(dv_quot >> p_q);
                        state_q      <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/pxs_search_chk.sv
module pxs_search_chk #(
    parameter int unsigned PW = 24,
    parameter int unsigned KW = 5,
    parameter int unsigned NW = 7,
    parameter int unsigned XW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o,
    input logic [KW-1:0] k_o,
    input logic [NW-1:0] n_o,
    input logic [XW-1:0] p_o,
    input logic [PW-1:0] period_out_o
);
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    a_r2_hold_results: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(k_o) && $stable(n_o) && $stable(p_o)
                     && $stable(period_out_o) && $stable(err_o)));

    // R4 and R7: error results carry zero fields
    a_r4_err_zero: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> (k_o == '0 && n_o == '0 && p_o == '0
                               && period_out_o == '0));

    a_r6_fields_nonzero: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o) |-> (k_o != '0 && n_o != '0));

    a_r5_exp_range: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o) |-> (p_o == XW'(2) || p_o == XW'(3)));
endmodule

bind pxs_search_top pxs_search_chk #(.PW(PW), .KW(KW), .NW(NW), .XW(XW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .k_o          (k_o),
    .n_o          (n_o),
    .p_o          (p_o),
    .period_out_o (period_out_o)
);

// File: tb/pxs_search_top_test.sv
module pxs_search_top_test;
    localparam int CLK_PERIOD = 10;
    localparam longint BASE = 256016;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [23:0] period_i = '0;
    logic        busy_o, done_o, err_o;
    logic [4:0]  k_o;
    logic [6:0]  n_o;
    logic [1:0]  p_o;
    logic [23:0] period_out_o;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pxs_search_top uut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .period_i     (period_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o),
        .k_o          (k_o),
        .n_o          (n_o),
        .p_o          (p_o),
        .period_out_o (period_out_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Arithmetic model of the search, written from the requirements
    task automatic model(input longint req, output bit e, output longint ek,
                         output longint en, output longint ep, output longint eper);
        longint per, l, best, m, nn, r;
        per = (req < 5000) ? 5000 : req;
        e = 0; ek = 0; en = 0; ep = 0; eper = 0;
        if (per > (BASE << 3)) begin
            e = 1;
            return;
        end
        ep = ((per * 16) < BASE) ? 3 : 2;
        l = per << ep;
        best = l;
        for (int kk = 1; kk < 32; kk++) begin
            m = BASE * kk;
            nn = m / l;
            r = m % l;
            if (nn != 0 && nn < 128 && r < best) begin
                ek = kk; en = nn; best = r;
            end
        end
        if (ek == 0) begin
            e = 1; ep = 0;
            return;
        end
        eper = ((BASE * ek) / en) >> ep;
    endtask

    // Launch a request; optionally poke a second start mid-run
    task automatic run(input longint req, input longint model_req, input bit poke);
        bit e;
        longint ek, en, ep, eper;
        int waited;
        model(model_req, e, ek, en, ep, eper);
        @(negedge clk);
        period_i = 24'(req);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (done_o) begin
            chk(e == 1, "R4 early done", 0, 1);
        end else begin
            chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
            if (poke) begin
                repeat (3) @(negedge clk);
                period_i = 24'd1900000;
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
            end
            waited = 0;
            while (!done_o && waited < 5000) begin
                @(negedge clk);
                waited++;
            end
        end
        chk(done_o == 1'b1, "R9 done seen", done_o, 1);
        chk(busy_o == 1'b0, "R9 busy low at done", busy_o, 0);
        chk(err_o == e, "R4 R7 err", err_o, e);
        chk(longint'(k_o) == ek, "R6 k", k_o, ek);
        chk(longint'(n_o) == en, "R6 n", n_o, en);
        chk(longint'(p_o) == ep, "R5 p", p_o, ep);
        chk(longint'(period_out_o) == eper, "R8 period", period_out_o, eper);
        @(negedge clk);
        chk(done_o == 1'b0, "R9 done pulse", done_o, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1 flags", {busy_o, done_o, err_o}, 0);
        chk(k_o == 0 && n_o == 0 && p_o == 0 && period_out_o == 0, "R1 fields",
            period_out_o, 0);

        // R3 floor
        run(0, 5000, 0);
        run(4999, 5000, 0);
        run(5000, 5000, 0);
        // R5 exponent boundary
        run(16000, 16000, 0);
        chk(p_o == 2'd3, "R5 p at 16000", p_o, 3);
        run(16001, 16001, 0);
        chk(p_o == 2'd2, "R5 p at 16001", p_o, 2);
        // R4 rejection and R7 no-candidate
        run(2048129, 2048129, 0);
        chk(err_o == 1'b1, "R4 reject", err_o, 1);
        run(24'hFFFFFF, 24'hFFFFFF, 0);
        run(2048128, 2048128, 0);
        chk(err_o == 1'b1, "R7 no candidate", err_o, 1);
        run(2000000, 2000000, 0);
        run(1900000, 1900000, 0);
        // R2 start while busy is ignored
        run(39721, 39721, 1);

        // R6 R8 sweep over the legal range
        for (int i = 0; i < 90; i++) begin
            run(longint'(3000 + i * 22987), longint'(3000 + i * 22987), 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule